// File: doc/BRIEF.md
# Arbiter Vote Fine-Phase Linearizer

This block turns the outputs of a bank of parallel arbiter latches into a signed fine phase value. Each arbiter reports one bit: whether the first edge arrived before the second. The latch thresholds are spread at random, so the share of "first edge early" votes follows a Gaussian cumulative curve of the time difference. The curve is steep near zero and flattens towards its ends.

On each sample strobe the block counts the votes in a two-stage pipelined population count. It reports the count relative to the midpoint as a signed delta. It also uses the count as the index into a programmable table that holds the inverse of the curve, which gives a linearized fine code. A range flag marks counts that fall in the flat tails, where the curve no longer resolves time.

The table is loaded through a simple address/data/write port, typically after a measurement of the real curve. The result and its valid strobe appear three clock cycles after the strobe that captured the votes.

Top module: `vote_linearizer`

## Requirements
- R1: A sample_i high at clock edge k raises valid_o for exactly one cycle, after edge k+2. valid_o is never high without a matching sample_i.
- R2: vote_delta_o equals the number of ones in votes_i captured with the strobe, minus 32, as a signed value. The result does not depend on which bits hold the ones.
- R3: fine_code_o equals the table entry whose index is the vote count (0 to 64), as the table stood when the count was looked up.
- R4: After reset, table entry k holds k minus 32 in 8-bit two's complement.
- R5: A cycle with lut_wr_en_i high and lut_wr_addr_i from 0 to 64 replaces that entry with lut_wr_data_i. A write to an address above 64 changes no entry.
- R6: out_of_range_o is high with a result whose vote count is below 10 or above 54, and low for counts 10 through 54.
- R7: Without sample_i, changes on votes_i produce no valid_o, and fine_code_o, vote_delta_o and out_of_range_o hold their last values.
- R8: During and right after reset, valid_o, fine_code_o, vote_delta_o and out_of_range_o are all zero.
- R9: Strobes on consecutive cycles give results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, the delayed reference edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Capture strobe for votes_i |
| votes_i | input | 64 | One vote per arbiter, 1 = first edge early |
| lut_wr_en_i | input | 1 | Table write enable |
| lut_wr_addr_i | input | 7 | Table entry index |
| lut_wr_data_i | input | 8 | Signed value to store |
| valid_o | output | 1 | Result strobe |
| fine_code_o | output | 8 | Signed linearized fine code |
| vote_delta_o | output | 8 | Signed vote count minus midpoint |
| out_of_range_o | output | 1 | Count lies outside the linear region |

## Verification
Vote vectors hold the same count packed at the low end, packed at the high end and scattered across all groups. Agreement across all three shows that every group of the first adder stage takes part, and that no bit position carries extra weight. The counts 0, 32 and 64, and the flag edges 9/10 and 54/55, separate the midpoint offset and the end entries of the table from off-by-one errors in the limits. Rewritten entries, a write to an address outside the table, and a burst of back-to-back strobes show whether the write decode is exact and whether the pipeline keeps its results in order.

// File: rtl/vote_lin_pkg.sv
package vote_lin_pkg;

  // Value loaded into table entry idx at reset: a plain ramp around mid.
  function automatic logic [15:0] ramp_entry(input int idx, input int mid);
    return 16'(idx - mid);
  endfunction

  // True when a vote count lies outside [lo, hi].
  function automatic logic beyond_linear(input int cnt, input int lo, input int hi);
    return (cnt < lo) || (cnt > hi);
  endfunction

endpackage

// File: rtl/vote_popcount.sv
module vote_popcount #(
  parameter int N_ARB = 64,
  parameter int GRP   = 8,
  localparam int CNT_W = $clog2(N_ARB + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N_ARB-1:0] votes,
  output logic             out_valid,
  output logic [CNT_W-1:0] count
);
  localparam int N_GRP  = N_ARB / GRP;
  localparam int PART_W = $clog2(GRP + 1);

  logic [N_GRP-1:0][PART_W-1:0] part_d, part_q;
  logic                         v1_q;
  logic [CNT_W-1:0]             total_d;

  // First stage: one small adder tree per group of arbiters.
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    always_comb begin
      part_d[g] = '0;
      for (int b = 0; b < GRP; b++)
        part_d[g] = part_d[g] + PART_W'(votes[g*GRP + b]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      part_q <= '0;
      v1_q   <= 1'b0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) part_q <= part_d;
    end
  end

  // Second stage: sum of the group counts.
  always_comb begin
    total_d = '0;
    for (int g = 0; g < N_GRP; g++)
      total_d = total_d + CNT_W'(part_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) count <= total_d;
    end
  end
endmodule

// File: rtl/vote_lut.sv
module vote_lut #(
  parameter int N_ARB  = 64,
  parameter int CODE_W = 8,
  localparam int CNT_W = $clog2(N_ARB + 1),
  localparam int DEPTH = N_ARB + 1,
  localparam int MID   = N_ARB / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CNT_W-1:0]  rd_addr,
  output logic [CODE_W-1:0] rd_data
);
  import vote_lin_pkg::*;

  logic [DEPTH-1:0][CODE_W-1:0] entry_q;

  // One register per entry; an address above DEPTH-1 matches none of them.
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_addr == CNT_W'(k));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q[k] <= CODE_W'(ramp_entry(k, MID));
      else if (hit) entry_q[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= entry_q[rd_addr];
  end
endmodule

// File: rtl/vote_range.sv
module vote_range #(
  parameter int CNT_W  = 7,
  parameter int LO_LIM = 10,
  parameter int HI_LIM = 54
) (
  input  logic [CNT_W-1:0] count,
  output logic             outside
);
  import vote_lin_pkg::*;
  assign outside = beyond_linear(int'(count), LO_LIM, HI_LIM);
endmodule

// File: rtl/vote_linearizer.sv
module vote_linearizer #(
  parameter int N_ARB  = 64,
  parameter int GRP    = 8,
  parameter int CODE_W = 8,
  parameter int LO_LIM = 10,
  parameter int HI_LIM = 54,
  localparam int CNT_W = $clog2(N_ARB + 1),
  localparam int DLT_W = CNT_W + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sample_i,
  input  logic [N_ARB-1:0]         votes_i,
  input  logic                     lut_wr_en_i,
  input  logic [CNT_W-1:0]         lut_wr_addr_i,
  input  logic [CODE_W-1:0]        lut_wr_data_i,
  output logic                     valid_o,
  output logic signed [CODE_W-1:0] fine_code_o,
  output logic signed [DLT_W-1:0]  vote_delta_o,
  output logic                     out_of_range_o
);
  localparam int MID = N_ARB / 2;

  // Named internal events
  logic             cnt_valid;
  logic [CNT_W-1:0] cnt_value;
  logic             cnt_outside;
  logic [CODE_W-1:0] lut_word;

  vote_popcount #(.N_ARB(N_ARB), .GRP(GRP)) u_pop (
    .clk(clk), .rst_n(rst_n), .in_valid(sample_i), .votes(votes_i),
    .out_valid(cnt_valid), .count(cnt_value)
  );

  vote_lut #(.N_ARB(N_ARB), .CODE_W(CODE_W)) u_lut (
    .clk(clk), .rst_n(rst_n), .wr_en(lut_wr_en_i), .wr_addr(lut_wr_addr_i),
    .wr_data(lut_wr_data_i), .rd_en(cnt_valid), .rd_addr(cnt_value),
    .rd_data(lut_word)
  );

  vote_range #(.CNT_W(CNT_W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)) u_rng (
    .count(cnt_value), .outside(cnt_outside)
  );

  // Third stage: aligned with the registered table read.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o        <= 1'b0;
      vote_delta_o   <= '0;
      out_of_range_o <= 1'b0;
    end else begin
      valid_o <= cnt_valid;
      if (cnt_valid) begin
        vote_delta_o   <= $signed(DLT_W'(cnt_value)) - $signed(DLT_W'(MID));
        out_of_range_o <= cnt_outside;
      end
    end
  end

  assign fine_code_o = $signed(lut_word);
endmodule

// File: rtl/vote_lin_checker.sv
module vote_lin_checker #(
  parameter int N_ARB  = 64,
  parameter int CODE_W = 8,
  parameter int LO_LIM = 10,
  parameter int HI_LIM = 54,
  localparam int DLT_W = $clog2(N_ARB + 1) + 1,
  localparam int MID   = N_ARB / 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sample_i,
  input logic                     valid_o,
  input logic signed [CODE_W-1:0] fine_code_o,
  input logic signed [DLT_W-1:0]  vote_delta_o,
  input logic                     out_of_range_o
);
  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_i |-> ##3 valid_o);

  p_delta_span_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (vote_delta_o >= -MID) && (vote_delta_o <= N_ARB - MID));

  p_flag_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> out_of_range_o ==
      ((vote_delta_o < (LO_LIM - MID)) || (vote_delta_o > (HI_LIM - MID))));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(fine_code_o) && $stable(vote_delta_o) && $stable(out_of_range_o));
endmodule

bind vote_linearizer vote_lin_checker #(
  .N_ARB(N_ARB), .CODE_W(CODE_W), .LO_LIM(LO_LIM), .HI_LIM(HI_LIM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .valid_o(valid_o),
  .fine_code_o(fine_code_o), .vote_delta_o(vote_delta_o),
  .out_of_range_o(out_of_range_o)
);

// File: tb/vote_linearizer_bench.sv
`timescale 1ns/1ps
module vote_linearizer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_i = 1'b0;
  logic [63:0] votes_i = '0;
  logic        lut_wr_en_i = 1'b0;
  logic [6:0]  lut_wr_addr_i = '0;
  logic [7:0]  lut_wr_data_i = '0;
  logic        valid_o;
  logic signed [7:0] fine_code_o;
  logic signed [7:0] vote_delta_o;
  logic        out_of_range_o;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [7:0] model_lut [0:64];

  always #2.5 clk = ~clk;

  vote_linearizer u_vote_linearizer (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .votes_i(votes_i),
    .lut_wr_en_i(lut_wr_en_i), .lut_wr_addr_i(lut_wr_addr_i),
    .lut_wr_data_i(lut_wr_data_i), .valid_o(valid_o),
    .fine_code_o(fine_code_o), .vote_delta_o(vote_delta_o),
    .out_of_range_o(out_of_range_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // n ones: mode 0 low end, 1 high end, 2 scattered over all groups
  function automatic logic [63:0] mk(input int n, input int mode);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) begin
      if (mode == 0)      v[i] = 1'b1;
      else if (mode == 1) v[63-i] = 1'b1;
      else                v[(i*37) % 64] = 1'b1;
    end
    return v;
  endfunction

  // Drives n_s strobes on consecutive cycles, checks each result three
  // negedges later, and checks valid_o low in the gap cycles.
  task automatic burst(input int cnts[4], input int modes[4], input int n_s, input string req);
    for (int step = 0; step < n_s + 3; step++) begin
      @(negedge clk);
      if (step >= 3) begin
        int n = cnts[step-3];
        chk(valid_o == 1'b1, "R1 valid", int'(valid_o), 1);
        chk(vote_delta_o == 8'(n - 32), {"R2 delta ", req}, int'(vote_delta_o), n - 32);
        chk(fine_code_o == model_lut[n], {"R3 code ", req},
            int'(fine_code_o), int'($signed(model_lut[n])));
        chk(out_of_range_o == ((n < 10) || (n > 54)), {"R6 flag ", req},
            int'(out_of_range_o), int'((n < 10) || (n > 54)));
      end else if (step >= 1 && n_s == 1) begin
        chk(valid_o == 1'b0, "R1 early valid", int'(valid_o), 0);
      end
      if (step < n_s) begin
        sample_i = 1'b1;
        votes_i  = mk(cnts[step], modes[step]);
      end else begin
        sample_i = 1'b0;
      end
    end
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 single pulse", int'(valid_o), 0);
  endtask

  task automatic one(input int n, input int mode, input string req);
    int c[4] = '{n, 0, 0, 0};
    int m[4] = '{mode, 0, 0, 0};
    burst(c, m, 1, req);
  endtask

  task automatic lut_write(input int addr, input logic [7:0] data);
    @(negedge clk);
    lut_wr_en_i = 1'b1; lut_wr_addr_i = 7'(addr); lut_wr_data_i = data;
    @(negedge clk);
    lut_wr_en_i = 1'b0;
    if (addr <= 64) model_lut[addr] = data;
  endtask

  task automatic t_reset;
    chk(valid_o == 0, "R8 valid", int'(valid_o), 0);
    chk(fine_code_o == 0, "R8 code", int'(fine_code_o), 0);
    chk(vote_delta_o == 0, "R8 delta", int'(vote_delta_o), 0);
    chk(out_of_range_o == 0, "R8 flag", int'(out_of_range_o), 0);
  endtask

  task automatic t_patterns;  // R2 R3 R4 with three bit layouts
    for (int m = 0; m < 3; m++) begin
      one(0, m, "R4 empty");
      one(32, m, "R4 mid");
      one(64, m, "R4 full");
      one(21, m, "R2 layout");
    end
  endtask

  task automatic t_range;  // R6 boundaries
    one(9, 2, "R6 below");
    one(10, 2, "R6 low edge");
    one(54, 2, "R6 high edge");
    one(55, 2, "R6 above");
  endtask

  task automatic t_write;  // R5
    lut_write(40, 8'h7f);
    lut_write(0, 8'h80);
    lut_write(64, 8'h33);
    one(40, 0, "R5 rewritten");
    one(0, 0, "R5 entry0");
    one(64, 1, "R5 entry64");
    lut_write(100, 8'h55);
    lut_write(65, 8'h44);
    one(36, 2, "R5 alias 36");
    one(1, 2, "R5 alias 1");
    one(64, 2, "R5 top kept");
  endtask

  task automatic t_ignore;  // R7
    logic signed [7:0] c0, d0;
    logic f0;
    c0 = fine_code_o; d0 = vote_delta_o; f0 = out_of_range_o;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      votes_i = mk(5 + i * 9, i % 3);
      chk(valid_o == 0, "R7 no valid", int'(valid_o), 0);
      chk(fine_code_o == c0, "R7 code held", int'(fine_code_o), int'(c0));
      chk(vote_delta_o == d0 && out_of_range_o == f0, "R7 delta/flag held",
          int'(vote_delta_o), int'(d0));
    end
  endtask

  task automatic t_stream;  // R9
    int c[4] = '{3, 60, 32, 47};
    int m[4] = '{2, 1, 0, 2};
    burst(c, m, 4, "R9 stream");
  endtask

  initial begin
    for (int k = 0; k <= 64; k++) model_lut[k] = 8'(k - 32);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_patterns();
    t_range();
    t_write();
    t_ignore();
    t_stream();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule